// File: doc/BRIEF.md
# Power-On Strap Capture and Clock Rate Selector

This block sits beside the clock synthesizer of a system clock generator. While power-on reset is held, six shared pins are read as configuration straps: a three-bit rate code, the memory clock source choice, the desktop or mobile mode, and the CPU driver voltage choice. On the first clock edge after reset is released the levels are frozen, and from then on the shared pins are switched into output mode to carry clocks.

A software control bit decides whether the rate code in use comes from the frozen straps or from a three-bit code written by software. From the code in use the block gives the nominal CPU, PCI, AGP and SDRAM clock rates in units of 10 kHz. It also gives the control levels for the other clock domains: the SDRAM source select, the output enables of the two mode-dependent pins, the enable of the two clock-stop inputs, and the CPU driver voltage select. The synthesizer, the dividers and the pad drivers use these outputs and are outside this block.

Top module: `strap_freq_ctrl`

## Requirements
- R1: While rst_n is low at a rising clk edge, after that edge strap_pin_oe_o is all zeros, capture_done_o is 0, dual_pin_oe_o is 2'b00 and stop_inputs_en_o is 0.
- R2: straps_o holds the strap_pin_i levels seen at the last rising edge with rst_n low. Once reset is released, later changes on strap_pin_i do not change straps_o. Bit positions: [2:0] rate code, [3] SDRAM follows CPU, [4] desktop mode, [5] CPU low-voltage drivers.
- R3: After the first rising edge with rst_n high, capture_done_o is 1 and strap_pin_oe_o is all ones until reset is asserted again.
- R4: active_code_o equals reg_sw_code_i when reg_sw_sel_i is 1 and straps_o[2:0] when it is 0. It follows these inputs in the same cycle.
- R5: cpu_rate_o, in 10 kHz units, for codes 7 down to 0 is 10000, 9525, 8330, 7500, 7500, 6850, 6680, 6000.
- R6: pci_rate_o for codes 7 down to 0 is 3330, 3175, 3330, 3000, 3750, 3425, 3340, 3000, and agp_rate_o is always twice pci_rate_o.
- R7: sdram_follow_cpu_o equals straps_o[3]. sdram_rate_o equals cpu_rate_o when it is 1 and agp_rate_o when it is 0.
- R8: After capture, a desktop strap of 1 sets desktop_mode_o to 1, dual_pin_oe_o to 2'b11 and stop_inputs_en_o to 0. A desktop strap of 0 gives desktop_mode_o 0, dual_pin_oe_o 2'b00 and stop_inputs_en_o 1.
- R9: cpu_low_volt_o equals straps_o[5], where 1 selects 2.5 V CPU drivers and 0 selects 3.3 V.
- R10: Asserting reset again re-opens the capture. The new strap levels replace the old ones at the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| strap_pin_i | input | 6 | Levels on the shared strap pins |
| reg_sw_sel_i | input | 1 | 1: rate code from software, 0: from straps |
| reg_sw_code_i | input | 3 | Software rate code |
| strap_pin_oe_o | output | 6 | Output enables of the shared pins |
| straps_o | output | 6 | Captured strap levels |
| capture_done_o | output | 1 | Straps frozen, pins in output mode |
| active_code_o | output | 3 | Rate code in use |
| sdram_follow_cpu_o | output | 1 | SDRAM clock source: 1 CPU, 0 AGP |
| desktop_mode_o | output | 1 | Captured mode strap |
| dual_pin_oe_o | output | 2 | Output enables of the two mode-dependent pins |
| stop_inputs_en_o | output | 1 | Clock-stop inputs active (mobile mode) |
| cpu_low_volt_o | output | 1 | CPU drivers: 1 for 2.5 V, 0 for 3.3 V |
| cpu_rate_o | output | 16 | CPU clock rate, 10 kHz units |
| pci_rate_o | output | 16 | PCI clock rate, 10 kHz units |
| agp_rate_o | output | 16 | AGP clock rate, 10 kHz units |
| sdram_rate_o | output | 16 | SDRAM clock rate, 10 kHz units |

## Verification
The assertions expect rst_n to be held low from time zero until the strap levels are settled. They also expect rst_n to change only away from the rising clock edge, so that the last sampled reset edge defines the captured value. The stimulus meets both conditions. It starts every run in reset and drives both rst_n and the pins on the falling edge. During reset it changes the pin levels on every cycle and keeps a copy of the level present at the last reset edge. After release it keeps toggling the pins, which shows that the captured values do not move.

// File: rtl/strap_freq_pkg.sv
// Package: shared strap layout and the rate lookup functions.
// Assumes rates are expressed in 10 kHz units and fit in 16 bits.
package strap_freq_pkg;
    localparam int STRAP_W = 6;
    localparam int CODE_W  = 3;

    typedef struct packed {
        logic             cpu_low_volt;
        logic             desktop;
        logic             sd_follow_cpu;
        logic [CODE_W-1:0] code;
    } strap_t;

    // CPU clock rate for a rate code, 10 kHz units
    function automatic int cpu_rate_of(input logic [CODE_W-1:0] c);
        case (c)
            3'd7:    return 10000;
            3'd6:    return 9525;
            3'd5:    return 8330;
            3'd4:    return 7500;
            3'd3:    return 7500;
            3'd2:    return 6850;
            3'd1:    return 6680;
            default: return 6000;
        endcase
    endfunction

    // PCI clock rate for a rate code, 10 kHz units
    function automatic int pci_rate_of(input logic [CODE_W-1:0] c);
        case (c)
            3'd7:    return 3330;
            3'd6:    return 3175;
            3'd5:    return 3330;
            3'd4:    return 3000;
            3'd3:    return 3750;
            3'd2:    return 3425;
            3'd1:    return 3340;
            default: return 3000;
        endcase
    endfunction
endpackage

// File: rtl/strap_capture.sv
// Strap capture: tracks the pins during reset, freezes them at release and
// enables the pin outputs from then on. Assumes rst_n is synchronous.
module strap_capture #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] held_o,
    output logic [W-1:0] oe_o,
    output logic         done_o
);
    // Sample pins while in reset, hold them afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o <= pin_i;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b1;
        end
    end

    // One output enable flop per shared pin
    for (genvar i = 0; i < W; i++) begin : g_oe
        // Enable is off in reset, on after release
        always_ff @(posedge clk) begin
            if (!rst_n) oe_o[i] <= 1'b0;
            else        oe_o[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/freq_code_sel.sv
// Rate code selector: chooses between the captured code and software code.
// Purely combinational.
module freq_code_sel #(
    parameter int CW = 3
) (
    input  logic          sw_sel_i,
    input  logic [CW-1:0] sw_code_i,
    input  logic [CW-1:0] strap_code_i,
    output logic [CW-1:0] code_o
);
    // Software override wins when selected
    always_comb code_o = sw_sel_i ? sw_code_i : strap_code_i;
endmodule

// File: rtl/domain_rate_map.sv
// Domain rate map: turns a rate code into the per-domain nominal rates.
// Assumes RATE_W is wide enough for 2x the largest PCI rate.
module domain_rate_map
    import strap_freq_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              sd_follow_cpu_i,
    output logic [RATE_W-1:0] cpu_o,
    output logic [RATE_W-1:0] pci_o,
    output logic [RATE_W-1:0] agp_o,
    output logic [RATE_W-1:0] sdram_o
);
    // Table lookup and derived AGP / SDRAM rates
    always_comb begin
        cpu_o   = RATE_W'(cpu_rate_of(code_i));
        pci_o   = RATE_W'(pci_rate_of(code_i));
        agp_o   = RATE_W'(2 * pci_rate_of(code_i));
        sdram_o = sd_follow_cpu_i ? cpu_o : agp_o;
    end
endmodule

// File: rtl/strap_freq_ctrl.sv
// Top: power-on strap capture and clock rate selector.
// Assumes rst_n is low from power-up until the straps are settled.
module strap_freq_ctrl
    import strap_freq_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_pin_i,
    input  logic               reg_sw_sel_i,
    input  logic [CODE_W-1:0]  reg_sw_code_i,
    output logic [STRAP_W-1:0] strap_pin_oe_o,
    output logic [STRAP_W-1:0] straps_o,
    output logic               capture_done_o,
    output logic [CODE_W-1:0]  active_code_o,
    output logic               sdram_follow_cpu_o,
    output logic               desktop_mode_o,
    output logic [1:0]         dual_pin_oe_o,
    output logic               stop_inputs_en_o,
    output logic               cpu_low_volt_o,
    output logic [RATE_W-1:0]  cpu_rate_o,
    output logic [RATE_W-1:0]  pci_rate_o,
    output logic [RATE_W-1:0]  agp_rate_o,
    output logic [RATE_W-1:0]  sdram_rate_o
);
    strap_t held;

    strap_capture #(.W(STRAP_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (strap_pin_i),
        .held_o (held),
        .oe_o   (strap_pin_oe_o),
        .done_o (capture_done_o)
    );

    freq_code_sel #(.CW(CODE_W)) u_sel (
        .sw_sel_i     (reg_sw_sel_i),
        .sw_code_i    (reg_sw_code_i),
        .strap_code_i (held.code),
        .code_o       (active_code_o)
    );

    domain_rate_map #(.RATE_W(RATE_W)) u_map (
        .code_i          (active_code_o),
        .sd_follow_cpu_i (held.sd_follow_cpu),
        .cpu_o           (cpu_rate_o),
        .pci_o           (pci_rate_o),
        .agp_o           (agp_rate_o),
        .sdram_o         (sdram_rate_o)
    );

    // Per-domain control levels derived from the captured straps
    always_comb begin
        straps_o           = held;
        sdram_follow_cpu_o = held.sd_follow_cpu;
        desktop_mode_o     = held.desktop;
        cpu_low_volt_o     = held.cpu_low_volt;
        dual_pin_oe_o      = {2{capture_done_o & held.desktop}};
        stop_inputs_en_o   = capture_done_o & ~held.desktop;
    end
endmodule

// File: rtl/strap_freq_ctrl_chk.sv
// Checker for strap_freq_ctrl, bound to every instance of the top.
module strap_freq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  strap_pin_oe_o,
    input logic [5:0]  straps_o,
    input logic        capture_done_o,
    input logic        reg_sw_sel_i,
    input logic [2:0]  active_code_o,
    input logic        sdram_follow_cpu_o,
    input logic        desktop_mode_o,
    input logic [1:0]  dual_pin_oe_o,
    input logic        stop_inputs_en_o,
    input logic [15:0] cpu_rate_o,
    input logic [15:0] pci_rate_o,
    input logic [15:0] agp_rate_o,
    input logic [15:0] sdram_rate_o
);
    // R1
    pins_closed_before_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_done_o |-> (strap_pin_oe_o == 6'd0 && dual_pin_oe_o == 2'b00 && !stop_inputs_en_o));
    // R2
    straps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_done_o |=> $stable(straps_o));
    // R3
    pins_open_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_done_o |-> (&strap_pin_oe_o));
    // R3
    capture_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_done_o |=> capture_done_o);
    // R4
    strap_code_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sw_sel_i |-> active_code_o == straps_o[2:0]);
    // R6
    agp_double_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
        agp_rate_o == {pci_rate_o[14:0], 1'b0});
    // R7
    sdram_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_rate_o == (sdram_follow_cpu_o ? cpu_rate_o : agp_rate_o));
    // R8
    mode_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_done_o |-> (dual_pin_oe_o == {2{desktop_mode_o}} && stop_inputs_en_o == !desktop_mode_o));
endmodule

bind strap_freq_ctrl strap_freq_ctrl_chk u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .strap_pin_oe_o     (strap_pin_oe_o),
    .straps_o           (straps_o),
    .capture_done_o     (capture_done_o),
    .reg_sw_sel_i       (reg_sw_sel_i),
    .active_code_o      (active_code_o),
    .sdram_follow_cpu_o (sdram_follow_cpu_o),
    .desktop_mode_o     (desktop_mode_o),
    .dual_pin_oe_o      (dual_pin_oe_o),
    .stop_inputs_en_o   (stop_inputs_en_o),
    .cpu_rate_o         (cpu_rate_o),
    .pci_rate_o         (pci_rate_o),
    .agp_rate_o         (agp_rate_o),
    .sdram_rate_o       (sdram_rate_o)
);

// File: tb/strap_freq_ctrl_tb.sv
module strap_freq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  strap_pin_i = 6'd0;
    logic        reg_sw_sel_i = 1'b0;
    logic [2:0]  reg_sw_code_i = 3'd0;
    logic [5:0]  strap_pin_oe_o, straps_o;
    logic        capture_done_o, sdram_follow_cpu_o, desktop_mode_o;
    logic [2:0]  active_code_o;
    logic [1:0]  dual_pin_oe_o;
    logic        stop_inputs_en_o, cpu_low_volt_o;
    logic [15:0] cpu_rate_o, pci_rate_o, agp_rate_o, sdram_rate_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] expect_straps;

    strap_freq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .strap_pin_i(strap_pin_i),
        .reg_sw_sel_i(reg_sw_sel_i), .reg_sw_code_i(reg_sw_code_i),
        .strap_pin_oe_o(strap_pin_oe_o), .straps_o(straps_o),
        .capture_done_o(capture_done_o), .active_code_o(active_code_o),
        .sdram_follow_cpu_o(sdram_follow_cpu_o), .desktop_mode_o(desktop_mode_o),
        .dual_pin_oe_o(dual_pin_oe_o), .stop_inputs_en_o(stop_inputs_en_o),
        .cpu_low_volt_o(cpu_low_volt_o), .cpu_rate_o(cpu_rate_o),
        .pci_rate_o(pci_rate_o), .agp_rate_o(agp_rate_o), .sdram_rate_o(sdram_rate_o)
    );

    always #2.5 clk = ~clk;

    function automatic int exp_cpu(input logic [2:0] c);
        int t[8] = '{6000, 6680, 6850, 7500, 7500, 8330, 9525, 10000};
        return t[c];
    endfunction

    function automatic int exp_pci(input logic [2:0] c);
        int t[8] = '{3000, 3340, 3425, 3750, 3000, 3330, 3175, 3330};
        return t[c];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Check all combinational rate outputs for current settings
    task automatic check_rates();
        logic [2:0] c;
        c = reg_sw_sel_i ? reg_sw_code_i : expect_straps[2:0];
        check("R4 active code", active_code_o, c);
        check("R5 cpu rate", cpu_rate_o, exp_cpu(c));
        check("R6 pci rate", pci_rate_o, exp_pci(c));
        check("R6 agp rate", agp_rate_o, 2 * exp_pci(c));
        check("R7 sdram rate", sdram_rate_o,
              expect_straps[3] ? exp_cpu(c) : 2 * exp_pci(c));
    endtask

    // Reset with toggling pins, release, and check capture state
    task automatic reset_cycle(input logic [5:0] final_pins);
        @(negedge clk);
        rst_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            strap_pin_i = 6'($urandom);
            @(negedge clk);
            // R1: one reset edge has passed
            check("R1 oe in reset", strap_pin_oe_o, 0);
            check("R1 done in reset", capture_done_o, 0);
            check("R1 dual oe in reset", dual_pin_oe_o, 0);
            check("R1 stop en in reset", stop_inputs_en_o, 0);
        end
        strap_pin_i = final_pins;
        expect_straps = final_pins;
        @(negedge clk);
        rst_n = 1'b1;
        strap_pin_i = ~final_pins;
        @(negedge clk);
        check("R3 done", capture_done_o, 1);
        check("R3 oe", strap_pin_oe_o, 6'h3f);
        check("R2 straps", straps_o, expect_straps);
        check("R7 sd follow", sdram_follow_cpu_o, expect_straps[3]);
        check("R8 desktop", desktop_mode_o, expect_straps[4]);
        check("R8 dual oe", dual_pin_oe_o, {2{expect_straps[4]}});
        check("R8 stop en", stop_inputs_en_o, !expect_straps[4]);
        check("R9 low volt", cpu_low_volt_o, expect_straps[5]);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        expect_straps = 6'd0;
        // Directed: desktop, follow CPU, code 7
        reset_cycle(6'b011_111);
        check_rates();
        // Directed: mobile, 2.5 V, follow AGP, code 0
        reset_cycle(6'b100_000);
        check_rates();
        // Directed: every software code, both SDRAM sources (R10 recapture)
        for (int s = 0; s < 2; s++) begin
            reset_cycle({2'b01, s[0], 3'b010});
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                reg_sw_sel_i = 1'b1;
                reg_sw_code_i = c[2:0];
                #1 check_rates();
            end
            reg_sw_sel_i = 1'b0;
            #1 check("R10 recaptured", straps_o, expect_straps);
        end
        // Random: captures, pin noise after release, software settings
        for (int it = 0; it < 60; it++) begin
            reset_cycle(6'($urandom));
            for (int j = 0; j < 10; j++) begin
                @(negedge clk);
                strap_pin_i = 6'($urandom);
                reg_sw_sel_i = 1'($urandom);
                reg_sw_code_i = 3'($urandom);
                #1 check_rates();
                @(negedge clk);
                // R2: pin noise ignored after capture
                check("R2 straps hold", straps_o, expect_straps);
                check("R3 oe hold", strap_pin_oe_o, 6'h3f);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule